// File: doc/BRIEF.md
# LUT Pair Configuration Version Permuter

This block holds the 16-bit contents of two chained 4-input lookup tables. A driving table feeds one input of a receiving table, called the link input. On request the block writes out a different encoding of the pair that computes the same logic function, so a fault in a stored bit that normal traffic never reaches can be moved to a location that is read often. A 4-bit version code names the receiving-table inputs whose incoming signal is seen inverted. The receiving content is rearranged so that stored bit `i` of the new image is bit `i XOR version` of the original. When the link input is part of the version, every bit of the driving content is complemented.

A per-input permission mask clears the version bits of inputs that no other table drives, since those signals cannot be inverted. A load strobe captures the original contents, the mask, a list of up to four rotation versions, the last list index and a rotation period, and it applies a version directly. While rotation is enabled, a period counter then applies the list entries one after another and wraps around at the end of the list. Two evaluation ports read both encoded tables at a given address, so the kept function can be seen at the pins.

Top module: `lvp_version_permuter`

## Requirements
- R1: While reset is high, and after it is released with no load, `drv_cfg`, `rcv_cfg` and `cur_ver` are zero and `done` is low.
- R2: One clock edge after `load` is sampled high, `cur_ver` equals `ver_in & inv_mask` and `rcv_cfg[i]` equals `rcv_orig[i XOR cur_ver]` for every i from 0 to 15. Address bit 0 is input A and bit 3 is input D.
- R3: After an apply, `drv_cfg` is the bitwise complement of the stored driving content when `cur_ver` bit LINK_INPUT is set (default 2, input C). Otherwise it is that content unchanged.
- R4: `done` is high in the cycle after each apply (load or rotation step) and low otherwise. The configuration outputs do not change in any cycle where `done` is low.
- R5: Version 0 gives `rcv_cfg == rcv_orig` and `drv_cfg == drv_orig`.
- R6: Version bits cleared by `inv_mask` have no effect on either configuration output, including the driver complement.
- R7: Receiving content 0xABBA under version 0xB becomes 0xD55D.
- R8: With `rot_en` high and a stored period P above 0, a rotation step happens every P cycles after the load edge. It applies the next entry of the stored list (entry k in `rot_list[4k+3:4k]`, starting at entry 0), masked by the stored mask, to the stored originals. After entry `rot_last` it wraps to entry 0.
- R9: For any `drv_addr` and `rcv_addr`, `rcv_out` equals the stored original receiving content read at `rcv_addr` with its link bit replaced by the original driving content at `drv_addr`. `drv_out` is `drv_cfg[drv_addr]`.
- R10: With `rot_en` low, or a stored period of 0, no rotation step occurs and the outputs hold.
- R11: A load in the same cycle as a due rotation step wins: the loaded version is applied and rotation restarts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture originals and settings, apply `ver_in` |
| drv_orig | input | 16 | Original driving-table content |
| rcv_orig | input | 16 | Original receiving-table content |
| ver_in | input | 4 | Version applied on load |
| inv_mask | input | 4 | Inputs that may be inverted |
| rot_en | input | 1 | Rotation enable |
| rot_period | input | PERIOD_W | Cycles between rotation steps, 0 = none |
| rot_list | input | 4*DEPTH | Rotation version list |
| rot_last | input | IDX_W | Index of last list entry used |
| drv_addr | input | 4 | Driving-table evaluation address |
| rcv_addr | input | 4 | Logical receiving-table input values |
| drv_cfg | output | 16 | Encoded driving content |
| rcv_cfg | output | 16 | Encoded receiving content |
| cur_ver | output | 4 | Effective version in force |
| done | output | 1 | Apply-complete pulse |
| drv_out | output | 1 | Encoded driving-table output |
| rcv_out | output | 1 | Encoded receiving-table output |

## Verification
The hardest case to reach is a load arriving on the same edge as a due rotation step. The bench sets the period to one so that a step is due on every edge, and then loads a version that is not in the list. The list wrap is reached by running past the last entry with a three-cycle period. For the kept function, every receiving address is swept together with a different driving address under versions where the link bit is set and where it is masked.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
    localparam int LUT_INPUTS = 4;
    localparam int LUT_BITS   = 1 << LUT_INPUTS;

    typedef logic [LUT_BITS-1:0]   lut_cfg_t;
    typedef logic [LUT_INPUTS-1:0] ver_t;

    typedef struct packed {
        lut_cfg_t drv;
        lut_cfg_t rcv;
    } pair_cfg_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LOAD = 2'd1,
        SRC_ROT  = 2'd2
    } apply_src_e;

    function automatic logic lut_read(input lut_cfg_t c, input ver_t a);
        return c[a];
    endfunction
endpackage

// File: rtl/lvp_permute.sv
module lvp_permute
    import lvp_pkg::*;
#(
    parameter int LINK_INPUT = 2
) (
    input  pair_cfg_t orig,
    input  ver_t      ver,
    output pair_cfg_t enc
);
    lut_cfg_t rcv_perm;

    for (genvar i = 0; i < LUT_BITS; i++) begin : g_bit
        assign rcv_perm[i] = orig.rcv[LUT_INPUTS'(i) ^ ver];
    end

    assign enc.rcv = rcv_perm;
    assign enc.drv = ver[LINK_INPUT] ? ~orig.drv : orig.drv;
endmodule

// File: rtl/lvp_rotator.sv
module lvp_rotator
    import lvp_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int PERIOD_W = 8,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      restart,
    input  logic                      run,
    input  logic [PERIOD_W-1:0]       period_new,
    input  logic [IDX_W-1:0]          last_new,
    input  logic [DEPTH*LUT_INPUTS-1:0] list_new,
    output logic                      step,
    output ver_t                      step_ver
);
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    last_q;
    ver_t                list_q [DEPTH];

    assign step     = run && !restart && (period_q != '0) && (cnt_q == period_q - PERIOD_W'(1));
    assign step_ver = list_q[idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            for (int k = 0; k < DEPTH; k++) list_q[k] <= '0;
        end else if (restart) begin
            period_q <= period_new;
            cnt_q    <= '0;
            idx_q    <= '0;
            last_q   <= last_new;
            for (int k = 0; k < DEPTH; k++) list_q[k] <= list_new[k*LUT_INPUTS +: LUT_INPUTS];
        end else if (run && (period_q != '0)) begin
            if (step) begin
                cnt_q <= '0;
                idx_q <= (idx_q == last_q) ? '0 : idx_q + IDX_W'(1);
            end else begin
                cnt_q <= cnt_q + PERIOD_W'(1);
            end
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (period_q != '0) |-> (cnt_q < period_q)); // R8
    AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (rst)
        idx_q <= last_q); // R8
endmodule

// File: rtl/lvp_eval.sv
module lvp_eval
    import lvp_pkg::*;
#(
    parameter int LINK_INPUT = 2
) (
    input  pair_cfg_t cfg,
    input  ver_t      cur_ver,
    input  ver_t      drv_addr,
    input  ver_t      rcv_addr,
    output logic      drv_out,
    output logic      rcv_out
);
    ver_t phys;

    always_comb begin
        drv_out          = lut_read(cfg.drv, drv_addr);
        phys             = rcv_addr ^ cur_ver;
        phys[LINK_INPUT] = drv_out;
        rcv_out          = lut_read(cfg.rcv, phys);
    end
endmodule

// File: rtl/lvp_version_permuter.sv
module lvp_version_permuter
    import lvp_pkg::*;
#(
    parameter int PERIOD_W   = 8,
    parameter int DEPTH      = 4,
    parameter int LINK_INPUT = 2,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [15:0]                 drv_orig,
    input  logic [15:0]                 rcv_orig,
    input  logic [3:0]                  ver_in,
    input  logic [3:0]                  inv_mask,
    input  logic                        rot_en,
    input  logic [PERIOD_W-1:0]         rot_period,
    input  logic [DEPTH*4-1:0]          rot_list,
    input  logic [IDX_W-1:0]            rot_last,
    input  logic [3:0]                  drv_addr,
    input  logic [3:0]                  rcv_addr,
    output logic [15:0]                 drv_cfg,
    output logic [15:0]                 rcv_cfg,
    output logic [3:0]                  cur_ver,
    output logic                        done,
    output logic                        drv_out,
    output logic                        rcv_out
);
    pair_cfg_t  orig_q, cfg_q, src_orig, enc;
    ver_t       mask_q, ver_q, next_ver, step_ver;
    logic       step, done_q;
    apply_src_e src;

    lvp_rotator #(.DEPTH(DEPTH), .PERIOD_W(PERIOD_W)) u_rot (
        .clk(clk), .rst(rst), .restart(load), .run(rot_en),
        .period_new(rot_period), .last_new(rot_last), .list_new(rot_list),
        .step(step), .step_ver(step_ver)
    );

    always_comb begin
        if (load)      src = SRC_LOAD;
        else if (step) src = SRC_ROT;
        else           src = SRC_NONE;
        if (src == SRC_LOAD) begin
            src_orig = '{drv: drv_orig, rcv: rcv_orig};
            next_ver = ver_in & inv_mask;
        end else begin
            src_orig = orig_q;
            next_ver = step_ver & mask_q;
        end
    end

    lvp_permute #(.LINK_INPUT(LINK_INPUT)) u_perm (
        .orig(src_orig), .ver(next_ver), .enc(enc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            orig_q <= '0;
            mask_q <= '0;
            cfg_q  <= '0;
            ver_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (src != SRC_NONE);
            if (src == SRC_LOAD) begin
                orig_q <= src_orig;
                mask_q <= inv_mask;
            end
            if (src != SRC_NONE) begin
                cfg_q <= enc;
                ver_q <= next_ver;
            end
        end
    end

    lvp_eval #(.LINK_INPUT(LINK_INPUT)) u_eval (
        .cfg(cfg_q), .cur_ver(ver_q), .drv_addr(drv_addr), .rcv_addr(rcv_addr),
        .drv_out(drv_out), .rcv_out(rcv_out)
    );

    assign drv_cfg = cfg_q.drv;
    assign rcv_cfg = cfg_q.rcv;
    assign cur_ver = ver_q;
    assign done    = done_q;

    ver_t ref_addr;
    always_comb begin
        ref_addr             = rcv_addr;
        ref_addr[LINK_INPUT] = orig_q.drv[drv_addr];
    end

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(drv_cfg) && $stable(rcv_cfg))); // R4
    AST_LOAD_DONE: assert property (@(posedge clk) disable iff (rst)
        load |=> done); // R4
    AST_BIT0_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rcv_cfg[0] == orig_q.rcv[cur_ver]); // R2
    AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
        $countones(rcv_cfg) == $countones(orig_q.rcv)); // R2
    AST_FUNC_KEPT: assert property (@(posedge clk) disable iff (rst)
        rcv_out == orig_q.rcv[ref_addr]); // R9
endmodule

// File: tb/tb_lvp_version_permuter.sv
module tb_lvp_version_permuter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] drv_orig = '0, rcv_orig = '0;
    logic [3:0]  ver_in = '0, inv_mask = '0;
    logic        rot_en = 1'b0;
    logic [7:0]  rot_period = '0;
    logic [15:0] rot_list = '0;
    logic [1:0]  rot_last = '0;
    logic [3:0]  drv_addr = '0, rcv_addr = '0;
    logic [15:0] drv_cfg, rcv_cfg;
    logic [3:0]  cur_ver;
    logic        done, drv_out, rcv_out;

    int checks = 0;
    int errors = 0;

    localparam int LINK = 2;
    localparam int NVEC = 6;
    // drv, rcv, version, mask
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h1234, 16'hABBA, 4'hB, 4'hF},
        {16'hF0F0, 16'h8001, 4'h4, 4'hF},
        {16'h00FF, 16'h1357, 4'h0, 4'hF},
        {16'h5A5A, 16'hC3A5, 4'hF, 4'h3},
        {16'h6996, 16'h0F1E, 4'h4, 4'hB},
        {16'hBEEF, 16'hDEAD, 4'h7, 4'hE}
    };

    lvp_version_permuter dut (
        .clk(clk), .rst(rst), .load(load), .drv_orig(drv_orig), .rcv_orig(rcv_orig),
        .ver_in(ver_in), .inv_mask(inv_mask), .rot_en(rot_en), .rot_period(rot_period),
        .rot_list(rot_list), .rot_last(rot_last), .drv_addr(drv_addr), .rcv_addr(rcv_addr),
        .drv_cfg(drv_cfg), .rcv_cfg(rcv_cfg), .cur_ver(cur_ver), .done(done),
        .drv_out(drv_out), .rcv_out(rcv_out)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] perm(input logic [15:0] o, input logic [3:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = o[4'(i) ^ v];
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] d, input logic [15:0] r,
                           input logic [3:0] v, input logic [3:0] m);
        @(negedge clk);
        drv_orig = d; rcv_orig = r; ver_in = v; inv_mask = m; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic chk_func(input logic [15:0] d, input logic [15:0] r);
        for (int a = 0; a < 16; a++) begin
            logic [3:0] la;
            rcv_addr = 4'(a);
            drv_addr = ~4'(a);
            #1;
            la = 4'(a);
            la[LINK] = d[~4'(a)];
            chk(rcv_out == r[la], "R9 rcv_out", 16'(rcv_out), 16'(r[la]));
            chk(drv_out == drv_cfg[~4'(a)], "R9 drv_out", 16'(drv_out), 16'(drv_cfg[~4'(a)]));
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  eff;
        logic [3:0]  seq [4];
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(rcv_cfg == 0 && drv_cfg == 0, "R1 cfg in reset", rcv_cfg, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(cur_ver == 0 && done == 0, "R1 after release", {11'b0, done, cur_ver}, 16'h0);

        // Table of static versions: R2 R3 R5 R6
        for (int n = 0; n < NVEC; n++) begin
            logic [15:0] d, r;
            d = VEC[n][39:24]; r = VEC[n][23:8];
            eff = VEC[n][7:4] & VEC[n][3:0];
            do_load(d, r, VEC[n][7:4], VEC[n][3:0]);
            chk(done == 1'b1, "R4 done after load", 16'(done), 16'h1);
            chk(cur_ver == eff, "R2 cur_ver", 16'(cur_ver), 16'(eff));
            chk(rcv_cfg == perm(r, eff), "R2 R6 rcv_cfg", rcv_cfg, perm(r, eff));
            chk(drv_cfg == (eff[LINK] ? ~d : d), "R3 R6 drv_cfg", drv_cfg, eff[LINK] ? ~d : d);
            if (eff == 0) begin
                chk(rcv_cfg == r && drv_cfg == d, "R5 identity", rcv_cfg, r);
            end
            if (n == 0) begin
                chk(rcv_cfg == 16'hD55D, "R7 test vector", rcv_cfg, 16'hD55D);
            end
            chk_func(d, r);
            @(negedge clk);
            chk(done == 1'b0, "R4 done single pulse", 16'(done), 16'h0);
            chk(rcv_cfg == perm(r, eff), "R10 hold without rotation", rcv_cfg, perm(r, eff));
        end

        // Rotation with period 3 and list wrap: R8
        rot_list = {4'h0, 4'h9, 4'h6, 4'h4};
        rot_last = 2'd2;
        rot_period = 8'd3;
        rot_en = 1'b1;
        do_load(16'h1F2E, 16'hABBA, 4'h1, 4'hF);
        chk(cur_ver == 4'h1, "R8 load before rotation", 16'(cur_ver), 16'h1);
        seq[0] = 4'h4; seq[1] = 4'h6; seq[2] = 4'h9; seq[3] = 4'h4;
        for (int s = 0; s < 4; s++) begin
            logic [3:0] prev;
            prev = cur_ver;
            repeat (2) @(negedge clk);
            chk(done == 0 && cur_ver == prev, "R8 no step early", 16'(cur_ver), 16'(prev));
            @(negedge clk);
            chk(done == 1 && cur_ver == seq[s], "R8 step version", 16'(cur_ver), 16'(seq[s]));
            chk(rcv_cfg == perm(16'hABBA, seq[s]), "R8 step content", rcv_cfg, perm(16'hABBA, seq[s]));
            chk(drv_cfg == (seq[s][LINK] ? ~16'h1F2E : 16'h1F2E), "R3 step driver", drv_cfg,
                seq[s][LINK] ? ~16'h1F2E : 16'h1F2E);
        end
        chk_func(16'h1F2E, 16'hABBA);

        // Rotation enabled but period 0: R10
        rot_period = 8'd0;
        do_load(16'h3C3C, 16'h7E81, 4'h2, 4'hF);
        repeat (8) begin
            @(negedge clk);
            chk(done == 0 && cur_ver == 4'h2, "R10 period zero", 16'(cur_ver), 16'h2);
        end

        // Load wins over a due step: R11
        rot_period = 8'd1;
        do_load(16'h0001, 16'h8421, 4'h2, 4'hF);
        chk(cur_ver == 4'h2, "R11 load applied", 16'(cur_ver), 16'h2);
        @(negedge clk);
        chk(done == 1 && cur_ver == 4'h4, "R11 step each cycle", 16'(cur_ver), 16'h4);
        do_load(16'h0001, 16'h8421, 4'h8, 4'hF);
        chk(cur_ver == 4'h8, "R11 load beats step", 16'(cur_ver), 16'h8);
        chk(rcv_cfg == perm(16'h8421, 4'h8), "R11 load content", rcv_cfg, perm(16'h8421, 4'h8));
        @(negedge clk);
        chk(cur_ver == 4'h4, "R11 restart at entry 0", 16'(cur_ver), 16'h4);

        // Rotation disabled: R10
        rot_en = 1'b0;
        @(negedge clk);
        eff = cur_ver;
        repeat (5) @(negedge clk);
        chk(done == 0 && cur_ver == eff, "R10 rot_en low", 16'(cur_ver), 16'(eff));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule